// File: doc/BRIEF.md
# Position Compare Status and Register-Write Handshake

This block sits between a cyclic process-data exchange and a small register bank. The bank holds an absolute encoder position, which is read-only and arrives as a parallel word, and a writable compare value. On every clock the block compares the live position with the compare register. From that comparison it drives three registered status bits: a magnitude relation, a live equality bit, and a sticky match flag. The sticky flag holds a seen match until software clears it.

Software changes the compare register through a four-phase write handshake. It presents an address, data and a request bit. When the block takes the request, it raises an acknowledge and reports in a separate success bit whether the addressed register was written. The acknowledge stays high, and blocks any further write, until the request bit has been seen low.

Register addresses: 0 is the position (read-only), 1 is the compare value, and every other address is unmapped.

Top module: `poscmp_wr_ctrl`

## Requirements
- R1: One clock after the position and compare value are presented, `ge_o` is 1 when position >= compare value (unsigned), and 0 when position < compare value.
- R2: One clock after the position and compare value are presented, `eq_o` is 1 exactly when position equals compare value.
- R3: `match_o` is 0 after reset. It becomes 1 one clock after the position has equalled the compare value.
- R4: Once set, `match_o` stays 1 until a clock in which `clr_match_i` is 1 and the position differs from the compare value. One clock after such a clock it reads 0.
- R5: When `clr_match_i` is 1 in the same clock as an equality, the match wins and `match_o` stays 1.
- R6: With `wr_ack_o` at 0 and `wr_req_i` at 1, `wr_ack_o` goes to 1 on the next clock. If `wr_addr_i` is 1 (the compare register), `wr_data_i` is written to the compare register, visible on `cmp_val_o` that same clock, and `wr_ok_o` reads 1.
- R7: While `wr_ack_o` is 1 and `wr_req_i` stays 1, no write is accepted, whatever the address and data. `wr_ack_o`, `wr_ok_o` and `cmp_val_o` keep their values.
- R8: `wr_ack_o` returns to 0 one clock after `wr_req_i` is seen at 0 while `wr_ack_o` is 1. `wr_ok_o` keeps the result of the last write.
- R9: A write started at address 0 (the read-only position) or at any address other than 0 and 1 sets `wr_ok_o` to 0 and leaves `cmp_val_o` unchanged. `wr_ack_o` still rises.
- R10: After reset, all outputs are 0 and the compare register holds 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pos_i | input | POS_W | Live absolute position word |
| wr_req_i | input | 1 | Write request from output data |
| wr_addr_i | input | ADDR_W | Register address of the write |
| wr_data_i | input | POS_W | Data to write |
| clr_match_i | input | 1 | Request to clear the sticky match flag |
| ge_o | output | 1 | Position >= compare value |
| eq_o | output | 1 | Position == compare value |
| match_o | output | 1 | Sticky match flag |
| wr_ack_o | output | 1 | Write acknowledge; blocks new writes while 1 |
| wr_ok_o | output | 1 | Last write reached its register |
| cmp_val_o | output | POS_W | Current compare register contents |

## Verification
The bench builds the block with its defaults: POS_W=32, SLICE_W=8 and ADDR_W=4. With four comparator slices, the bench can choose position and compare pairs that differ only in the lowest slice or only in the highest slice. This exercises how the per-slice results combine, as well as the all-ones and all-zero extremes. The 4-bit address reaches both mapped registers and unmapped addresses up to 15. Writes attempted while the acknowledge is high carry fresh data, so a wrongly accepted write shows up on `cmp_val_o`.

// File: rtl/poscmp_pkg.sv
package poscmp_pkg;
  typedef enum logic {
    HS_IDLE = 1'b0,
    HS_BUSY = 1'b1
  } hs_state_e;

  localparam int unsigned DEF_POS_ADDR = 0;
  localparam int unsigned DEF_CMP_ADDR = 1;
endpackage

// File: rtl/poscmp_mag_cmp.sv
// Sliced unsigned compare: per-slice results merged from the top slice down
module poscmp_mag_cmp #(
  parameter int unsigned W       = 32,
  parameter int unsigned SLICE_W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         ge_o,
  output logic         eq_o
);
  localparam int unsigned N_SL  = (W + SLICE_W - 1) / SLICE_W;
  localparam int unsigned EXT_W = N_SL * SLICE_W;

  logic [EXT_W-1:0] a_x, b_x;
  logic [N_SL-1:0]  sl_gt, sl_eq;
  logic             gt_acc, eq_acc;

  assign a_x = EXT_W'(a_i);
  assign b_x = EXT_W'(b_i);

  for (genvar i = 0; i < N_SL; i++) begin : g_slice
    assign sl_gt[i] = a_x[i*SLICE_W +: SLICE_W] > b_x[i*SLICE_W +: SLICE_W];
    assign sl_eq[i] = a_x[i*SLICE_W +: SLICE_W] == b_x[i*SLICE_W +: SLICE_W];
  end

  always_comb begin
    gt_acc = 1'b0;
    eq_acc = 1'b1;
    for (int i = N_SL - 1; i >= 0; i--) begin
      gt_acc = gt_acc | (eq_acc & sl_gt[i]);
      eq_acc = eq_acc & sl_eq[i];
    end
  end

  assign ge_o = gt_acc | eq_acc;
  assign eq_o = eq_acc;
endmodule

// File: rtl/poscmp_status.sv
// Registered relation, live equality and sticky match flag
module poscmp_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ge_i,
  input  logic eq_i,
  input  logic clr_i,
  output logic ge_o,
  output logic eq_o,
  output logic match_o
);
  logic ge_q, eq_q, match_q, match_d;

  // a coincident match overrides the clear
  always_comb begin
    match_d = match_q;
    if (eq_i)       match_d = 1'b1;
    else if (clr_i) match_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ge_q    <= 1'b0;
      eq_q    <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ge_q    <= ge_i;
      eq_q    <= eq_i;
      match_q <= match_d;
    end
  end

  assign ge_o    = ge_q;
  assign eq_o    = eq_q;
  assign match_o = match_q;
endmodule

// File: rtl/poscmp_wr_port.sv
// Four-phase write handshake and the writable compare register
module poscmp_wr_port
  import poscmp_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CMP_ADDR = DEF_CMP_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ack_o,
  output logic              ok_o,
  output logic [DATA_W-1:0] cmp_o
);
  localparam logic [ADDR_W-1:0] CMP_A = ADDR_W'(CMP_ADDR);

  hs_state_e         state_q, state_d;
  logic              ok_q, ok_d;
  logic [DATA_W-1:0] cmp_q, cmp_d;
  logic              hit;

  // only the compare register is writable; position and holes reject
  assign hit = (addr_i == CMP_A);

  always_comb begin
    state_d = state_q;
    ok_d    = ok_q;
    cmp_d   = cmp_q;
    unique case (state_q)
      HS_IDLE: if (req_i) begin
        state_d = HS_BUSY;
        ok_d    = hit;
        if (hit) cmp_d = data_i;
      end
      HS_BUSY: if (!req_i) state_d = HS_IDLE;
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_IDLE;
      ok_q    <= 1'b0;
      cmp_q   <= '0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      cmp_q   <= cmp_d;
    end
  end

  assign ack_o = (state_q == HS_BUSY);
  assign ok_o  = ok_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/poscmp_wr_ctrl.sv
module poscmp_wr_ctrl
  import poscmp_pkg::*;
#(
  parameter int unsigned POS_W    = 32,
  parameter int unsigned SLICE_W  = 8,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CMP_ADDR = DEF_CMP_ADDR
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [POS_W-1:0]  pos_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [POS_W-1:0]  wr_data_i,
  input  logic              clr_match_i,
  output logic              ge_o,
  output logic              eq_o,
  output logic              match_o,
  output logic              wr_ack_o,
  output logic              wr_ok_o,
  output logic [POS_W-1:0]  cmp_val_o
);
  logic [POS_W-1:0] cmp_q;
  logic             ge_c, eq_c;

  poscmp_wr_port #(
    .DATA_W  (POS_W),
    .ADDR_W  (ADDR_W),
    .CMP_ADDR(CMP_ADDR)
  ) u_wr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (wr_req_i),
    .addr_i(wr_addr_i),
    .data_i(wr_data_i),
    .ack_o (wr_ack_o),
    .ok_o  (wr_ok_o),
    .cmp_o (cmp_q)
  );

  poscmp_mag_cmp #(
    .W      (POS_W),
    .SLICE_W(SLICE_W)
  ) u_cmp (
    .a_i (pos_i),
    .b_i (cmp_q),
    .ge_o(ge_c),
    .eq_o(eq_c)
  );

  poscmp_status u_sts (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ge_i   (ge_c),
    .eq_i   (eq_c),
    .clr_i  (clr_match_i),
    .ge_o   (ge_o),
    .eq_o   (eq_o),
    .match_o(match_o)
  );

  assign cmp_val_o = cmp_q;
endmodule

// File: rtl/poscmp_wr_ctrl_chk.sv
module poscmp_wr_ctrl_chk #(
  parameter int unsigned POS_W    = 32,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CMP_ADDR = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [POS_W-1:0]  pos_i,
  input logic              wr_req_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              clr_match_i,
  input logic              ge_o,
  input logic              eq_o,
  input logic              match_o,
  input logic              wr_ack_o,
  input logic              wr_ok_o,
  input logic [POS_W-1:0]  cmp_val_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_ge_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (ge_o == ($past(pos_i) >= $past(cmp_val_o))));

  assert_eq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (eq_o == ($past(pos_i) == $past(cmp_val_o))));

  assert_eq_sets_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eq_o |-> match_o);

  assert_flag_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !clr_match_i) |=> match_o);

  assert_flag_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && clr_match_i && (pos_i != cmp_val_o)) |=> !match_o);

  assert_match_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_match_i && (pos_i == cmp_val_o)) |=> match_o);

  assert_ack_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ack_o && wr_req_i) |=> wr_ack_o);

  assert_busy_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack_o && wr_req_i) |=> (wr_ack_o && $stable(cmp_val_o) && $stable(wr_ok_o)));

  assert_ack_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ack_o && !wr_req_i) |=> !wr_ack_o);

  assert_bad_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_ack_o && wr_req_i && (wr_addr_i != ADDR_W'(CMP_ADDR)))
      |=> (!wr_ok_o && $stable(cmp_val_o)));

  assert_idle_no_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_req_i |=> $stable(cmp_val_o));
endmodule

bind poscmp_wr_ctrl poscmp_wr_ctrl_chk #(
  .POS_W   (POS_W),
  .ADDR_W  (ADDR_W),
  .CMP_ADDR(CMP_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pos_i      (pos_i),
  .wr_req_i   (wr_req_i),
  .wr_addr_i  (wr_addr_i),
  .clr_match_i(clr_match_i),
  .ge_o       (ge_o),
  .eq_o       (eq_o),
  .match_o    (match_o),
  .wr_ack_o   (wr_ack_o),
  .wr_ok_o    (wr_ok_o),
  .cmp_val_o  (cmp_val_o)
);

// File: tb/poscmp_wr_ctrl_test.sv
module poscmp_wr_ctrl_test;
  localparam int unsigned POS_W  = 32;
  localparam int unsigned ADDR_W = 4;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [POS_W-1:0]  pos_i = '0;
  logic              wr_req_i = 1'b0;
  logic [ADDR_W-1:0] wr_addr_i = '0;
  logic [POS_W-1:0]  wr_data_i = '0;
  logic              clr_match_i = 1'b0;
  logic              ge_o, eq_o, match_o, wr_ack_o, wr_ok_o;
  logic [POS_W-1:0]  cmp_val_o;

  always #4 clk_i = ~clk_i;

  poscmp_wr_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pos_i(pos_i), .wr_req_i(wr_req_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .clr_match_i(clr_match_i),
    .ge_o(ge_o), .eq_o(eq_o), .match_o(match_o), .wr_ack_o(wr_ack_o),
    .wr_ok_o(wr_ok_o), .cmp_val_o(cmp_val_o)
  );

  typedef struct {
    logic             ge, eq, match, ack, ok;
    logic [POS_W-1:0] cmp;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  // bench model state
  logic [POS_W-1:0] m_cmp = '0;
  logic m_match = 0, m_ack = 0, m_ok = 0;

  task automatic chk(input string tag, input string what,
                     input logic [POS_W-1:0] act, input logic [POS_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic drive(input logic [POS_W-1:0] pos, input logic req,
                       input logic [ADDR_W-1:0] addr, input logic [POS_W-1:0] data,
                       input logic clr, input string tag);
    exp_t e;
    pos_i = pos; wr_req_i = req; wr_addr_i = addr; wr_data_i = data; clr_match_i = clr;
    e.ge = (pos >= m_cmp);
    e.eq = (pos == m_cmp);
    if (e.eq)     m_match = 1'b1;
    else if (clr) m_match = 1'b0;
    if (!m_ack && req) begin
      m_ack = 1'b1;
      m_ok  = (addr == 1);
      if (addr == 1) m_cmp = data;
    end else if (m_ack && !req) begin
      m_ack = 1'b0;
    end
    e.match = m_match; e.ack = m_ack; e.ok = m_ok; e.cmp = m_cmp; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [ADDR_W-1:0] addr, input logic [POS_W-1:0] data,
                    input logic [POS_W-1:0] pos, input string tag);
    drive(pos, 1'b1, addr, data, 1'b0, tag);
    drive(pos, 1'b0, addr, data, 1'b0, "R8");
  endtask

  // monitor: compare 2 ns after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (rst_ni && exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        chk(e.tag, "ge_o R1",    POS_W'(ge_o),     POS_W'(e.ge));
        chk(e.tag, "eq_o R2",    POS_W'(eq_o),     POS_W'(e.eq));
        chk(e.tag, "match_o R3", POS_W'(match_o),  POS_W'(e.match));
        chk(e.tag, "wr_ack_o R6",POS_W'(wr_ack_o), POS_W'(e.ack));
        chk(e.tag, "wr_ok_o R6", POS_W'(wr_ok_o),  POS_W'(e.ok));
        chk(e.tag, "cmp_val_o R9", cmp_val_o,      e.cmp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R10: reset state
    chk("R10", "ge_o",  POS_W'(ge_o),  '0);
    chk("R10", "eq_o",  POS_W'(eq_o),  '0);
    chk("R10", "match_o", POS_W'(match_o), '0);
    chk("R10", "wr_ack_o", POS_W'(wr_ack_o), '0);
    chk("R10", "wr_ok_o", POS_W'(wr_ok_o), '0);
    chk("R10", "cmp_val_o", cmp_val_o, '0);
    rst_ni = 1'b1;

    // R6/R8: load compare value, hold request then release
    drive(32'h5, 1'b1, 4'd1, 32'h0000_1000, 1'b0, "R6");
    drive(32'h5, 1'b1, 4'd1, 32'h0000_1000, 1'b0, "R7");
    drive(32'h5, 1'b0, 4'd1, 32'h0000_1000, 1'b0, "R8");
    drive(32'h5, 1'b0, 4'd1, 32'h0000_1000, 1'b0, "R8");

    // R1/R2: low-slice and high-slice differences
    drive(32'h0000_0FFF, 1'b0, 4'd0, '0, 1'b0, "R1");
    drive(32'h0000_1001, 1'b0, 4'd0, '0, 1'b0, "R1");
    drive(32'h0100_0000, 1'b0, 4'd0, '0, 1'b0, "R1");
    drive(32'h0100_1000, 1'b0, 4'd0, '0, 1'b0, "R2");
    drive(32'h0000_1000, 1'b0, 4'd0, '0, 1'b0, "R2");
    drive(32'h0000_0000, 1'b0, 4'd0, '0, 1'b0, "R3");
    drive(32'h0000_2000, 1'b0, 4'd0, '0, 1'b0, "R4");
    // R4: clear away from match
    drive(32'h0000_2000, 1'b0, 4'd0, '0, 1'b1, "R4");
    drive(32'h0000_2000, 1'b0, 4'd0, '0, 1'b0, "R4");
    // R5: clear coincident with match
    drive(32'h0000_1000, 1'b0, 4'd0, '0, 1'b1, "R5");
    drive(32'h0000_0800, 1'b0, 4'd0, '0, 1'b1, "R5");
    drive(32'h0000_0800, 1'b0, 4'd0, '0, 1'b0, "R4");

    // R9: read-only position address and unmapped address
    wr(4'd0, 32'hDEAD_BEEF, 32'h0000_0800, "R9");
    wr(4'd7, 32'hDEAD_BEEF, 32'h0000_0800, "R9");
    wr(4'd15, 32'h0000_0800, 32'h0000_0800, "R9");

    // R7: write attempts while acknowledge is high
    drive(32'h0, 1'b1, 4'd1, 32'hFFFF_FFFF, 1'b0, "R6");
    drive(32'h0, 1'b1, 4'd1, 32'h1234_5678, 1'b0, "R7");
    drive(32'h0, 1'b1, 4'd0, 32'h0000_0000, 1'b0, "R7");
    drive(32'h0, 1'b0, 4'd1, 32'h1234_5678, 1'b0, "R8");

    // R1/R2 extremes at all-ones compare value
    drive(32'hFFFF_FFFF, 1'b0, 4'd0, '0, 1'b0, "R2");
    drive(32'hFFFF_FFFE, 1'b0, 4'd0, '0, 1'b0, "R1");
    drive(32'h7FFF_FFFF, 1'b0, 4'd0, '0, 1'b1, "R4");

    // compare value zero: any position is >=
    wr(4'd1, 32'h0, 32'h0, "R6");
    drive(32'h0, 1'b0, 4'd0, '0, 1'b0, "R2");
    drive(32'h8000_0000, 1'b0, 4'd0, '0, 1'b0, "R1");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule